// File: doc/BRIEF.md
# Extended-Format Precision Rounder

This unit takes one value in the 80-bit extended floating-point layout (a sign bit, a 15-bit biased exponent and a 64-bit significand whose integer bit is stored explicitly) and rounds its significand to one of three widths: the full 64 bits, 53 bits or 24 bits. The result keeps the 80-bit layout. Only the low significand bits are cleared, and the exponent changes only when rounding carries out of the top bit. The rounding direction comes from a per-operation mode input. A truncate input forces round-toward-zero for that one operation, which is what single-precision operand preparation for multiply and divide needs.

A sign operation is applied before rounding: keep, clear (absolute value) or invert (negate). Moves, absolute values and negations therefore all pass through the rounder at the chosen precision. Because the directed modes see the new sign, a negate can round away from zero while the same value without the negate is truncated. Exponent all-ones values (infinities and NaNs) bypass the rounder. The unit reports an inexact flag.

Operands enter through a valid/ready handshake and leave one cycle later through a second valid/ready handshake. The output stage holds one result at a time.

Top module: `fxr_rounder`

## Requirements
- R1: Precision code 0 (extended) and the reserved code 3 return the significand and exponent unchanged, with inexact clear.
- R2: Precision code 1 (single) keeps significand bits [63:40] and code 2 (double) keeps bits [63:11]. Every bit below the kept field is zero in the result.
- R3: Mode code 0 rounds to nearest with ties to an even kept LSB, code 1 truncates, code 2 rounds toward minus infinity and code 3 rounds toward plus infinity. Codes 2 and 3 increment the kept field only when the (post-sign-operation) sign points away from zero in that direction and a discarded bit is set.
- R4: An increment that carries out of bit 63 yields significand 0x8000_0000_0000_0000 and an exponent one higher.
- R5: With the truncate input high, the operation rounds toward zero whatever the mode input says. The next operation without it uses its own mode again.
- R6: An input whose exponent is 0x7FFF keeps its exponent and significand and reports inexact clear. An all-zero significand also comes out unchanged and exact.
- R7: Inexact is set exactly when at least one discarded significand bit is nonzero.
- R8: Sign-operation code 0 keeps the sign, code 1 clears it, code 2 inverts it and code 3 keeps it. The operation is applied before rounding and to the bypassed exponent-0x7FFF values as well.
- R9: in_ready is high when no result is held or out_ready is high. An accepted operand gives out_valid on the next cycle. A result held while out_ready is low stays stable, and no new operand is taken.
- R10: Synchronous active-high reset clears out_valid.
- R11: An input with exponent zero is rounded in place with no normalization, and its exponent stays zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand present |
| in_ready | output | 1 | Operand can be taken this cycle |
| in_sign | input | 1 | Operand sign |
| in_exp | input | 15 | Operand biased exponent |
| in_mant | input | 64 | Operand significand, integer bit at 63 |
| in_prec | input | 2 | Precision: 0 extended, 1 single, 2 double, 3 as extended |
| in_rmode | input | 2 | Mode: 0 nearest-even, 1 toward zero, 2 toward minus infinity, 3 toward plus infinity |
| in_sign_op | input | 2 | Sign operation: 0 keep, 1 clear, 2 invert, 3 keep |
| in_trunc | input | 1 | Force toward-zero for this operation |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_sign | output | 1 | Result sign |
| out_exp | output | 15 | Result biased exponent |
| out_mant | output | 64 | Result significand |
| out_inexact | output | 1 | A discarded bit was nonzero |

## Verification
A fault in the rounding datapath shows at the ports on the single result that follows the faulty operand, one cycle after acceptance. It appears as a wrong low kept bit, a missing carry into the exponent, or an inexact flag that disagrees with the discarded bits. A fault in the held-result register shows as a result that changes or vanishes while out_ready is low, or as in_ready rising while a result is still stuck. A lost truncate override shows only on the operation that carries it, while a sticky one shows on the operation right after it. The vector walk therefore places a truncated operation directly before an untruncated one on the same operand.

// File: rtl/fxr_pkg.sv
package fxr_pkg;

    localparam int EXP_W     = 15;
    localparam int MANT_W    = 64;
    localparam int NUM_LANES = 3;
    localparam int LANE_EXT  = 0;
    localparam int LANE_SGL  = 1;
    localparam int LANE_DBL  = 2;

    typedef enum logic [1:0] {
        PREC_EXT = 2'd0,
        PREC_SGL = 2'd1,
        PREC_DBL = 2'd2,
        PREC_RSV = 2'd3
    } prec_e;

    typedef enum logic [1:0] {
        RND_NEAR_EVEN = 2'd0,
        RND_ZERO      = 2'd1,
        RND_DOWN      = 2'd2,
        RND_UP        = 2'd3
    } rmode_e;

    typedef enum logic [1:0] {
        SGN_KEEP     = 2'd0,
        SGN_CLEAR    = 2'd1,
        SGN_FLIP     = 2'd2,
        SGN_KEEP_ALT = 2'd3
    } sgnop_e;

    typedef struct packed {
        logic              sign;
        logic [EXP_W-1:0]  exp;
        logic [MANT_W-1:0] mant;
    } xfloat_t;

    typedef struct packed {
        xfloat_t val;
        logic    inexact;
    } rres_t;

    // Decide whether the kept field is incremented.
    function automatic logic round_up(rmode_e mode, logic sign, logic lsb,
                                      logic guard, logic sticky);
        logic lost_any;
        lost_any = guard | sticky;
        case (mode)
            RND_NEAR_EVEN: return guard & (sticky | lsb);
            RND_ZERO:      return 1'b0;
            RND_DOWN:      return sign & lost_any;
            default:       return ~sign & lost_any;
        endcase
    endfunction

    function automatic logic apply_sign(sgnop_e op, logic sign);
        case (op)
            SGN_CLEAR: return 1'b0;
            SGN_FLIP:  return ~sign;
            default:   return sign;
        endcase
    endfunction

    function automatic rmode_e effective_mode(rmode_e mode, logic trunc);
        return trunc ? RND_ZERO : mode;
    endfunction

    function automatic int lane_of(prec_e prec);
        case (prec)
            PREC_SGL: return LANE_SGL;
            PREC_DBL: return LANE_DBL;
            default:  return LANE_EXT;
        endcase
    endfunction

endpackage

// File: rtl/fxr_prep.sv
module fxr_prep
    import fxr_pkg::*;
(
    input  xfloat_t operand,
    input  sgnop_e  sign_op,
    input  rmode_e  mode_req,
    input  logic    trunc,
    output xfloat_t adjusted,
    output rmode_e  mode_eff,
    output logic    special
);

    always_comb begin
        adjusted      = operand;
        adjusted.sign = apply_sign(sign_op, operand.sign);
        mode_eff      = effective_mode(mode_req, trunc);
        special       = &operand.exp;
    end

endmodule

// File: rtl/fxr_lane.sv
module fxr_lane
    import fxr_pkg::*;
#(
    parameter int KEEP = 64
) (
    input  logic              sign,
    input  logic [MANT_W-1:0] mant_i,
    input  rmode_e            mode,
    output logic [MANT_W-1:0] mant_o,
    output logic              carry_o,
    output logic              inexact_o
);

    localparam int DROP = MANT_W - KEEP;

    generate
        if (DROP == 0) begin : g_exact
            logic unused_exact;
            assign unused_exact = sign ^ mode[0] ^ mode[1];
            assign mant_o    = mant_i;
            assign carry_o   = 1'b0;
            assign inexact_o = 1'b0;
        end else begin : g_cut
            logic [KEEP-1:0] kept;
            logic [DROP-1:0] lost;
            logic [DROP-1:0] lost_below;
            logic            guard;
            logic            sticky;
            logic            bump;
            logic [KEEP:0]   sum;

            always_comb begin
                kept       = mant_i[MANT_W-1:DROP];
                lost       = mant_i[DROP-1:0];
                lost_below = lost << 1;
                guard      = lost[DROP-1];
                sticky     = |lost_below;
                bump       = round_up(mode, sign, kept[0], guard, sticky);
                sum        = {1'b0, kept} + {{KEEP{1'b0}}, bump};
                carry_o    = sum[KEEP];
                inexact_o  = guard | sticky;
                if (sum[KEEP]) begin
                    mant_o = {1'b1, {(MANT_W-1){1'b0}}};
                end else begin
                    mant_o = {sum[KEEP-1:0], {DROP{1'b0}}};
                end
            end
        end
    endgenerate

endmodule

// File: rtl/fxr_out_stage.sv
module fxr_out_stage
    import fxr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  take_valid,
    output logic  take_ready,
    input  rres_t take_data,
    output logic  hold_valid,
    input  logic  hold_ready,
    output rres_t hold_data
);

    logic  vld_q;
    rres_t data_q;

    assign take_ready = ~vld_q | hold_ready;
    assign hold_valid = vld_q;
    assign hold_data  = data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
        end else if (take_ready) begin
            vld_q <= take_valid;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
        end else if (take_valid && take_ready) begin
            data_q <= take_data;
        end
    end

endmodule

// File: rtl/fxr_rounder.sv
module fxr_rounder
    import fxr_pkg::*;
#(
    parameter int SGL_BITS = 24,
    parameter int DBL_BITS = 53
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              in_sign,
    input  logic [EXP_W-1:0]  in_exp,
    input  logic [MANT_W-1:0] in_mant,
    input  logic [1:0]        in_prec,
    input  logic [1:0]        in_rmode,
    input  logic [1:0]        in_sign_op,
    input  logic              in_trunc,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              out_sign,
    output logic [EXP_W-1:0]  out_exp,
    output logic [MANT_W-1:0] out_mant,
    output logic              out_inexact
);

    localparam int KEEP_TAB [NUM_LANES] = '{MANT_W, SGL_BITS, DBL_BITS};

    xfloat_t           operand;
    xfloat_t           adjusted;
    rmode_e            mode_eff;
    logic              special;
    logic [MANT_W-1:0] lane_mant    [NUM_LANES];
    logic              lane_carry   [NUM_LANES];
    logic              lane_inexact [NUM_LANES];
    rres_t             result;
    rres_t             held;

    assign operand = '{sign: in_sign, exp: in_exp, mant: in_mant};

    fxr_prep u_prep (
        .operand  (operand),
        .sign_op  (sgnop_e'(in_sign_op)),
        .mode_req (rmode_e'(in_rmode)),
        .trunc    (in_trunc),
        .adjusted (adjusted),
        .mode_eff (mode_eff),
        .special  (special)
    );

    generate
        for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
            fxr_lane #(.KEEP(KEEP_TAB[g])) u_lane (
                .sign      (adjusted.sign),
                .mant_i    (adjusted.mant),
                .mode      (mode_eff),
                .mant_o    (lane_mant[g]),
                .carry_o   (lane_carry[g]),
                .inexact_o (lane_inexact[g])
            );
        end
    endgenerate

    always_comb begin
        int sel;
        sel                 = lane_of(prec_e'(in_prec));
        result.val.sign     = adjusted.sign;
        if (special) begin
            result.val.exp  = adjusted.exp;
            result.val.mant = adjusted.mant;
            result.inexact  = 1'b0;
        end else begin
            result.val.exp  = adjusted.exp + {{(EXP_W-1){1'b0}}, lane_carry[sel]};
            result.val.mant = lane_mant[sel];
            result.inexact  = lane_inexact[sel];
        end
    end

    fxr_out_stage u_out (
        .clk        (clk),
        .rst        (rst),
        .take_valid (in_valid),
        .take_ready (in_ready),
        .take_data  (result),
        .hold_valid (out_valid),
        .hold_ready (out_ready),
        .hold_data  (held)
    );

    assign out_sign    = held.val.sign;
    assign out_exp     = held.val.exp;
    assign out_mant    = held.val.mant;
    assign out_inexact = held.inexact;

endmodule

// File: rtl/fxr_rounder_chk.sv
module fxr_rounder_chk
    import fxr_pkg::*;
#(
    parameter int SGL_BITS = 24
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_ready,
    input logic              in_sign,
    input logic [EXP_W-1:0]  in_exp,
    input logic [MANT_W-1:0] in_mant,
    input logic [1:0]        in_prec,
    input logic [1:0]        in_rmode,
    input logic [1:0]        in_sign_op,
    input logic              in_trunc,
    input logic              out_valid,
    input logic              out_ready,
    input logic              out_sign,
    input logic [EXP_W-1:0]  out_exp,
    input logic [MANT_W-1:0] out_mant,
    input logic              out_inexact
);

    localparam logic [MANT_W-1:0] SGL_LOW = {MANT_W{1'b1}} >> SGL_BITS;

    logic take;
    logic unused_chk;
    assign take       = in_valid && in_ready && !rst;
    assign unused_chk = in_sign ^ in_rmode[0] ^ in_rmode[1] ^ in_sign_op[0] ^ in_sign_op[1] ^ out_sign;

    AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_mant) && $stable(out_exp) && $stable(out_inexact)); // R9

    AST_BLOCK_INPUT: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |-> !in_ready); // R9

    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        take |=> out_valid); // R9

    AST_EXT_IDENTITY: assert property (@(posedge clk) disable iff (rst)
        take && (in_prec == 2'd0 || in_prec == 2'd3) |=>
        out_mant == $past(in_mant) && out_exp == $past(in_exp) && !out_inexact); // R1

    AST_SGL_LOW_CLEAR: assert property (@(posedge clk) disable iff (rst)
        take && in_prec == 2'd1 && in_exp != '1 |=> (out_mant & SGL_LOW) == '0); // R2

    AST_SPECIAL_PASS: assert property (@(posedge clk) disable iff (rst)
        take && in_exp == '1 |=>
        out_exp == $past(in_exp) && out_mant == $past(in_mant) && !out_inexact); // R6

    AST_TRUNC_NO_GROW: assert property (@(posedge clk) disable iff (rst)
        take && in_trunc && in_exp != '1 |=> out_exp == $past(in_exp)); // R5

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> !out_valid); // R10

endmodule

bind fxr_rounder fxr_rounder_chk #(.SGL_BITS(SGL_BITS)) u_chk (.*);

// File: tb/fxr_rounder_tb_top.sv
module fxr_rounder_tb_top;

    typedef struct packed {
        logic [1:0]  prec;
        logic [1:0]  mode;
        logic        trunc;
        logic [1:0]  sop;
        logic        sign;
        logic [14:0] exp;
        logic [63:0] mant;
        logic        e_sign;
        logic [14:0] e_exp;
        logic [63:0] e_mant;
        logic        e_inx;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 23;
    // prec: 0 ext, 1 sgl, 2 dbl, 3 reserved; mode: 0 RNE, 1 RZ, 2 RM, 3 RP; sop: 0 keep, 1 clear, 2 invert, 3 keep
    localparam vec_t VECS [NV] = '{
        '{2'd0, 2'd0, 1'b0, 2'd0, 1'b0, 15'h3FFF, 64'hC000000000000001, 1'b0, 15'h3FFF, 64'hC000000000000001, 1'b0, 8'd1},  // R1
        '{2'd1, 2'd0, 1'b0, 2'd0, 1'b0, 15'h3FFF, 64'h8000008000000000, 1'b0, 15'h3FFF, 64'h8000000000000000, 1'b1, 8'd3},  // R3 tie even
        '{2'd1, 2'd0, 1'b0, 2'd0, 1'b0, 15'h3FFF, 64'h8000018000000000, 1'b0, 15'h3FFF, 64'h8000020000000000, 1'b1, 8'd3},  // R3 tie odd
        '{2'd1, 2'd0, 1'b0, 2'd0, 1'b0, 15'h3FFF, 64'h8000008000000001, 1'b0, 15'h3FFF, 64'h8000010000000000, 1'b1, 8'd7},  // R7
        '{2'd1, 2'd1, 1'b0, 2'd0, 1'b0, 15'h3FFF, 64'hFFFFFFFFFFFFFFFF, 1'b0, 15'h3FFF, 64'hFFFFFF0000000000, 1'b1, 8'd2},  // R2
        '{2'd1, 2'd0, 1'b0, 2'd0, 1'b0, 15'h3FFF, 64'hFFFFFFFFFFFFFFFF, 1'b0, 15'h4000, 64'h8000000000000000, 1'b1, 8'd4},  // R4
        '{2'd2, 2'd3, 1'b0, 2'd0, 1'b0, 15'h3FFF, 64'h8000000000000001, 1'b0, 15'h3FFF, 64'h8000000000000800, 1'b1, 8'd3},  // R3 RP pos
        '{2'd2, 2'd3, 1'b0, 2'd0, 1'b1, 15'h3FFF, 64'h8000000000000001, 1'b1, 15'h3FFF, 64'h8000000000000000, 1'b1, 8'd3},  // R3 RP neg
        '{2'd2, 2'd2, 1'b0, 2'd0, 1'b1, 15'h3FFF, 64'h8000000000000001, 1'b1, 15'h3FFF, 64'h8000000000000800, 1'b1, 8'd3},  // R3 RM neg
        '{2'd2, 2'd0, 1'b0, 2'd0, 1'b0, 15'h3FFF, 64'h8000000000000400, 1'b0, 15'h3FFF, 64'h8000000000000000, 1'b1, 8'd2},  // R2 dbl tie
        '{2'd2, 2'd0, 1'b0, 2'd0, 1'b0, 15'h3FFF, 64'h8000000000000C00, 1'b0, 15'h3FFF, 64'h8000000000001000, 1'b1, 8'd2},  // R2 dbl up
        '{2'd1, 2'd3, 1'b1, 2'd0, 1'b0, 15'h3FFF, 64'hFFFFFFFFFFFFFFFF, 1'b0, 15'h3FFF, 64'hFFFFFF0000000000, 1'b1, 8'd5},  // R5 forced
        '{2'd1, 2'd3, 1'b0, 2'd0, 1'b0, 15'h3FFF, 64'hFFFFFFFFFFFFFFFF, 1'b0, 15'h4000, 64'h8000000000000000, 1'b1, 8'd5},  // R5 restored
        '{2'd2, 2'd0, 1'b0, 2'd0, 1'b0, 15'h3FFF, 64'h8000000000000800, 1'b0, 15'h3FFF, 64'h8000000000000800, 1'b0, 8'd7},  // R7 exact
        '{2'd1, 2'd3, 1'b0, 2'd0, 1'b0, 15'h7FFF, 64'hC000000000000001, 1'b0, 15'h7FFF, 64'hC000000000000001, 1'b0, 8'd6},  // R6 NaN
        '{2'd1, 2'd0, 1'b0, 2'd2, 1'b0, 15'h7FFF, 64'h8000000000000000, 1'b1, 15'h7FFF, 64'h8000000000000000, 1'b0, 8'd8},  // R8 inf negate
        '{2'd1, 2'd3, 1'b0, 2'd0, 1'b0, 15'h0000, 64'h0000000000000000, 1'b0, 15'h0000, 64'h0000000000000000, 1'b0, 8'd6},  // R6 zero
        '{2'd2, 2'd2, 1'b0, 2'd1, 1'b1, 15'h3FFF, 64'h8000000000000001, 1'b0, 15'h3FFF, 64'h8000000000000000, 1'b1, 8'd8},  // R8 clear
        '{2'd2, 2'd2, 1'b0, 2'd2, 1'b0, 15'h3FFF, 64'h8000000000000001, 1'b1, 15'h3FFF, 64'h8000000000000800, 1'b1, 8'd8},  // R8 invert
        '{2'd3, 2'd0, 1'b0, 2'd0, 1'b0, 15'h3FFF, 64'hC000000000000001, 1'b0, 15'h3FFF, 64'hC000000000000001, 1'b0, 8'd1},  // R1 reserved
        '{2'd1, 2'd0, 1'b0, 2'd0, 1'b0, 15'h7FFE, 64'hFFFFFFFFFFFFFFFF, 1'b0, 15'h7FFF, 64'h8000000000000000, 1'b1, 8'd4},  // R4 top exp
        '{2'd2, 2'd0, 1'b0, 2'd0, 1'b0, 15'h0000, 64'h0000000000000FFF, 1'b0, 15'h0000, 64'h0000000000001000, 1'b1, 8'd11}, // R11
        '{2'd0, 2'd0, 1'b0, 2'd3, 1'b1, 15'h3FFF, 64'h8000000000000000, 1'b1, 15'h3FFF, 64'h8000000000000000, 1'b0, 8'd8}   // R8 alt keep
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic        in_sign = 1'b0;
    logic [14:0] in_exp = '0;
    logic [63:0] in_mant = '0;
    logic [1:0]  in_prec = '0;
    logic [1:0]  in_rmode = '0;
    logic [1:0]  in_sign_op = '0;
    logic        in_trunc = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic        out_sign;
    logic [14:0] out_exp;
    logic [63:0] out_mant;
    logic        out_inexact;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    fxr_rounder dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_sign(in_sign), .in_exp(in_exp), .in_mant(in_mant), .in_prec(in_prec),
        .in_rmode(in_rmode), .in_sign_op(in_sign_op), .in_trunc(in_trunc),
        .out_valid(out_valid), .out_ready(out_ready), .out_sign(out_sign),
        .out_exp(out_exp), .out_mant(out_mant), .out_inexact(out_inexact)
    );

    task automatic check_bit(input string tag, input logic act, input logic exp_v);
        total++;
        if (act !== exp_v) begin
            bad++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp_v);
        end
    endtask

    task automatic check_res(input string tag, input logic [80:0] act, input logic [80:0] exp_v);
        total++;
        if (act !== exp_v) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp_v);
        end
    endtask

    task automatic drive(input vec_t v);
        in_valid   = 1'b1;
        in_prec    = v.prec;
        in_rmode   = v.mode;
        in_trunc   = v.trunc;
        in_sign_op = v.sop;
        in_sign    = v.sign;
        in_exp     = v.exp;
        in_mant    = v.mant;
    endtask

    function automatic logic [80:0] want(input vec_t v);
        return {v.e_sign, v.e_exp, v.e_mant, v.e_inx};
    endfunction

    function automatic logic [80:0] got();
        return {out_sign, out_exp, out_mant, out_inexact};
    endfunction

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_bit("R10 reset out_valid", out_valid, 1'b0);
        check_bit("R9 idle in_ready", in_ready, 1'b1);

        // Vector walk, one operand per cycle, consumer always ready.
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i]);
            @(negedge clk);
            check_bit($sformatf("R9 vec%0d out_valid", i), out_valid, 1'b1);
            check_res($sformatf("R%0d vec%0d result", VECS[i].req, i), got(), want(VECS[i]));
        end
        in_valid = 1'b0;
        @(negedge clk);
        check_bit("R9 drained", out_valid, 1'b0);

        // Backpressure: R9
        out_ready = 1'b0;
        drive(VECS[5]);
        @(negedge clk);
        check_bit("R9 held valid", out_valid, 1'b1);
        check_bit("R9 blocked in_ready", in_ready, 1'b0);
        drive(VECS[4]);
        @(negedge clk);
        check_res("R9 held stable", got(), want(VECS[5]));
        out_ready = 1'b1;
        @(negedge clk);
        check_res("R9 second after release", got(), want(VECS[4]));
        in_valid = 1'b0;
        @(negedge clk);
        check_bit("R9 empty after drain", out_valid, 1'b0);

        // Reset while a result is held: R10
        out_ready = 1'b0;
        drive(VECS[0]);
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        check_bit("R10 reset drops held result", out_valid, 1'b0);
        rst = 1'b0;
        out_ready = 1'b1;
        @(negedge clk);
        check_bit("R10 stays empty", out_valid, 1'b0);

        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            finish_run();
        end
    end

endmodule